// File: doc/BRIEF.md
# Eight-Instruction Single-Cycle Processor Core

This block is a 32-bit single-cycle processor that executes a reduced instruction set of eight operations: bitwise NOR, unsigned subtract, word load, word store, branch when a register is non-negative, register jump with link, and two halting traps. There is no immediate arithmetic at all. A program obtains constants by loading them from data memory, which is placed at byte address 0x100, just past the 64-word instruction region. The core holds a program counter and a 32-entry register file. It drives separate instruction and data memory ports, and the surrounding logic answers each port from synchronous arrays.

The core runs on a fast clock and retires one instruction per step enable. A local divider produces this enable once every `DIV` fast cycles, 16 by default. The divider leaves the memories enough fast cycles to return instruction data and then load data before the step commits. For observation, the core shows the program counter, the ALU result and both register operands of the instruction being executed. It also shows a sticky halted flag and an illegal-instruction flag.

Top module: `sub8_core`

## Requirements
- R1: While `rst_n` is low, `obs_pc` is 0 and both `halted` and `illegal` are 0.
- R2: `retire` is high for one fast cycle out of every `DIV`, with exactly `DIV` cycles between pulses. The program counter, registers and store strobe change only on a `retire` cycle.
- R3: Bit fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shift [10:6], funct [5:0] and offset [15:0]. An R-type instruction has opcode 0x00. R-type funct 0x27 writes the bitwise complement of (rs OR rt) into rd.
- R4: R-type funct 0x23 writes rs minus rt into rd, modulo 2^32, with no trap.
- R5: Opcode 0x23 loads the word at rs + sign-extended offset into rt. Opcode 0x2B stores rt to that same address, and `dmem_we` is high only in that instruction's `retire` cycle.
- R6: Opcode 0x01 with rt = 1 branches when rs is non-negative as a signed value. The branch target is PC+4 plus the sign-extended offset shifted left by two. Otherwise execution goes to PC+4.
- R7: R-type funct 0x09 jumps to rs with its two low bits cleared and writes PC+4 into rd. The jump target is the value rs held before the link write, even when rd equals rs.
- R8: R-type funct 0x0C or 0x0D sets `halted` and leaves `illegal` at 0. The PC then stays on the trapping instruction, and no register or memory write follows until reset.
- R9: Any other opcode, any opcode 0x01 with rt not equal to 1, any other funct, or any R-type with a non-zero shift field sets both `halted` and `illegal` and holds the PC.
- R10: Register 0 always reads as zero, and a write to it has no effect.
- R11: During a step, `obs_rs_val` and `obs_rt_val` show the operands of the current instruction. `obs_alu` shows the NOR result, the difference, or the load/store address.
- R12: `obs_pc` stays a multiple of four at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast memory-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 32 | Instruction fetch byte address (the PC) |
| imem_rdata | input | 32 | Instruction word returned by the fetch port |
| dmem_addr | output | 32 | Data byte address for load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, one cycle |
| dmem_rdata | input | 32 | Load data returned by the data port |
| retire | output | 1 | Step enable; the current instruction commits on this cycle |
| obs_pc | output | 32 | Program counter |
| obs_alu | output | 32 | ALU result of the current instruction |
| obs_rs_val | output | 32 | First register operand |
| obs_rt_val | output | 32 | Second register operand |
| halted | output | 1 | Core stopped by a trap or an illegal instruction |
| illegal | output | 1 | Stop was caused by an unsupported encoding |

## Verification
The collision that matters is a register jump whose link destination is also its source. In that single step, the register file is written with PC+4 while the same register supplies the jump target. The directed program loads a deliberately misaligned address into r5 and executes a jump-and-link from r5 into r5. The bench then checks three things: the captured operand in that step is still the loaded value, execution resumes at the aligned target, and a later store of r5 writes back PC+4. A second case of the same kind stores r0 after an attempted write to r0 in an earlier step.

// File: rtl/sub8_core.sv
module sub8_core #(
  parameter int DIV = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata,
  output logic        retire,
  output logic [31:0] obs_pc,
  output logic [31:0] obs_alu,
  output logic [31:0] obs_rs_val,
  output logic [31:0] obs_rt_val,
  output logic        halted,
  output logic        illegal
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;
  logic [31:0]   pc;
  logic [31:0]   rf [1:31];
  logic          stop_q, bad_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (retire) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
  assign retire = (cnt == CW'(DIV - 1));

  wire [31:0] ins = imem_rdata;
  wire [5:0]  op  = ins[31:26];
  wire [4:0]  rs  = ins[25:21];
  wire [4:0]  rt  = ins[20:16];
  wire [4:0]  rd  = ins[15:11];
  wire [4:0]  sh  = ins[10:6];
  wire [5:0]  fn  = ins[5:0];
  wire [31:0] offx = {{16{ins[15]}}, ins[15:0]};

  wire is_r    = (op == 6'h00) && (sh == 5'd0);
  wire is_nor  = is_r && (fn == 6'h27);
  wire is_subu = is_r && (fn == 6'h23);
  wire is_jalr = is_r && (fn == 6'h09);
  wire is_trap = is_r && ((fn == 6'h0C) || (fn == 6'h0D));
  wire is_lw   = (op == 6'h23);
  wire is_sw   = (op == 6'h2B);
  wire is_bgez = (op == 6'h01) && (rt == 5'd1);
  wire legal   = is_nor | is_subu | is_jalr | is_trap | is_lw | is_sw | is_bgez;

  wire [31:0] a = (rs == 5'd0) ? 32'd0 : rf[rs];
  wire [31:0] b = (rt == 5'd0) ? 32'd0 : rf[rt];

  wire [31:0] ea  = a + offx;
  wire [31:0] alu = is_nor ? ~(a | b) : (is_lw | is_sw) ? ea : (a - b);
  wire [31:0] pc4 = pc + 32'd4;
  wire [31:0] bt  = pc4 + {offx[29:0], 2'b00};

  wire        live  = retire && !stop_q;
  wire        wen   = live && (is_nor | is_subu | is_lw | is_jalr);
  wire [4:0]  widx  = is_lw ? rt : rd;
  wire [31:0] wdat  = is_lw ? dmem_rdata : is_jalr ? pc4 : alu;
  wire [31:0] npc   = is_jalr ? {a[31:2], 2'b00} : (is_bgez && !a[31]) ? bt : pc4;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc     <= '0;
      stop_q <= 1'b0;
      bad_q  <= 1'b0;
    end else if (live) begin
      if (!legal || is_trap) begin
        stop_q <= 1'b1;
        bad_q  <= !legal;
      end else begin
        pc <= npc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 1; i < 32; i++) rf[i] <= '0;
    end else if (wen && legal && (widx != 5'd0)) begin
      rf[widx] <= wdat;
    end
  end

  assign imem_addr  = pc;
  assign dmem_addr  = ea;
  assign dmem_wdata = b;
  assign dmem_we    = live && is_sw;
  assign obs_pc     = pc;
  assign obs_alu    = alu;
  assign obs_rs_val = a;
  assign obs_rt_val = b;
  assign halted     = stop_q;
  assign illegal    = bad_q;
endmodule

// File: rtl/sub8_core_chk.sv
module sub8_core_chk #(
  parameter int DIV = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        retire,
  input logic        dmem_we,
  input logic [31:0] obs_pc,
  input logic        halted,
  input logic        illegal
);
  localparam int GW = $clog2(DIV + 1) + 1;
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n || retire) gap <= '0;
    else                  gap <= gap + 1'b1;
  end

  assert_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> (gap == GW'(DIV - 1)));
  assert_gap_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gap < GW'(DIV));
  assert_pc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !retire |=> $stable(obs_pc));
  assert_store_in_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> retire);
  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(obs_pc)));
  assert_no_store_halted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !dmem_we);
  assert_illegal_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> halted);
  assert_pc_aligned_R12: assert property (@(posedge clk) disable iff (!rst_n)
    obs_pc[1:0] == 2'b00);
endmodule

bind sub8_core sub8_core_chk #(.DIV(DIV)) u_chk (.*);

// File: tb/test_sub8_core.sv
module test_sub8_core;
  localparam int DIV = 16;
  localparam logic [5:0] F_NOR = 6'h27, F_SUBU = 6'h23, F_JALR = 6'h09,
                         F_SYS = 6'h0C, F_BRK = 6'h0D;
  localparam logic [5:0] OP_LW = 6'h23, OP_SW = 6'h2B, OP_RI = 6'h01;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, retire, halted, illegal;
  logic [31:0] obs_pc, obs_alu, obs_rs_val, obs_rt_val;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  sub8_core #(.DIV(DIV)) i_sub8_core (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata), .retire(retire), .obs_pc(obs_pc), .obs_alu(obs_alu),
    .obs_rs_val(obs_rs_val), .obs_rt_val(obs_rt_val), .halted(halted),
    .illegal(illegal));

  always @(posedge clk) begin
    imem_rdata <= imem[imem_addr[7:2]];
    dmem_rdata <= dmem[dmem_addr[7:2]];
    if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
  end

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] cap_a, cap_b, cap_alu, cap_j;
  int gap_seen;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rty(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] ity(logic [5:0] op, int rs, int rt, logic [15:0] off);
    return {op, rs[4:0], rt[4:0], off};
  endfunction
  function automatic logic [31:0] e_nor(logic [31:0] x, logic [31:0] y);
    return ~(x | y);
  endfunction
  function automatic logic [31:0] e_sub(logic [31:0] x, logic [31:0] y);
    return x - y;
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) begin
      imem[i] = rty(0, 0, 0, F_BRK);
      dmem[i] = 32'h0;
    end
  endtask

  task automatic run(input int limit);
    int c = 0, last = -1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset pc", obs_pc, 32'h0);
    chk("R1 reset flags", {30'd0, halted, illegal}, 32'h0);
    rst_n = 1'b1;
    gap_seen = 0;
    while (!halted && c < limit) begin
      @(negedge clk);
      c++;
      if (retire) begin
        if (last >= 0 && gap_seen == 0) gap_seen = c - last;
        last = c;
        if (obs_pc == 32'd8) begin
          cap_a = obs_rs_val; cap_b = obs_rt_val; cap_alu = obs_alu;
        end
        if (obs_pc == 32'd40) cap_j = obs_rs_val;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd5150));
    clear_mem();
    dmem[0] = 32'h5;  dmem[1] = 32'hFFFF_FFF0; dmem[2] = 32'h42;
    dmem[10] = 32'h0; dmem[12] = 32'hDEAD; dmem[14] = 32'h7777;
    imem[0]  = ity(OP_LW, 0, 1, 16'h100);
    imem[1]  = ity(OP_LW, 0, 2, 16'h104);
    imem[2]  = rty(1, 2, 3, F_SUBU);
    imem[3]  = rty(1, 2, 4, F_NOR);
    imem[4]  = ity(OP_SW, 0, 3, 16'h120);
    imem[5]  = ity(OP_SW, 0, 4, 16'h124);
    imem[6]  = ity(OP_RI, 2, 1, 16'd5);
    imem[7]  = ity(OP_RI, 1, 1, 16'd1);
    imem[8]  = ity(OP_SW, 0, 1, 16'h128);
    imem[9]  = ity(OP_LW, 0, 5, 16'h108);
    imem[10] = rty(5, 0, 5, F_JALR);
    imem[16] = rty(1, 2, 0, F_SUBU);
    imem[17] = ity(OP_SW, 0, 5, 16'h12C);
    imem[18] = ity(OP_SW, 0, 0, 16'h130);
    imem[19] = ity(OP_RI, 0, 1, 16'd1);
    imem[21] = ity(OP_SW, 0, 1, 16'h134);
    imem[22] = rty(0, 0, 0, F_SYS);
    run(40 * DIV);
    chk("R2 step spacing", gap_seen, DIV);
    chk("R11 rs operand", cap_a, 32'h5);
    chk("R11 rt operand", cap_b, 32'hFFFF_FFF0);
    chk("R11 alu result", cap_alu, 32'h15);
    chk("R4 subu", dmem[8], e_sub(32'h5, 32'hFFFF_FFF0));
    chk("R3 nor", dmem[9], e_nor(32'h5, 32'hFFFF_FFF0));
    chk("R6 branch taken skips store", dmem[10], 32'h0);
    chk("R7 jalr link rd==rs", dmem[11], 32'd44);
    chk("R7 target uses pre-link value", cap_j, 32'h42);
    chk("R10 r0 write ignored", dmem[12], 32'h0);
    chk("R6 bgez on r0 taken", dmem[13], 32'h5);
    chk("R8 syscall pc", obs_pc, 32'd88);
    chk("R8 halted no illegal", {30'd0, halted, illegal}, 32'h2);
    repeat (4 * DIV) @(negedge clk);
    chk("R8 sticky pc", obs_pc, 32'd88);
    chk("R8 sticky halted", {31'd0, halted}, 32'h1);
    chk("R8 no late store", dmem[14], 32'h7777);

    for (int k = 0; k < 3; k++) begin
      clear_mem();
      dmem[8] = 32'h1234;
      imem[0] = rty(0, 0, 3, F_NOR);
      imem[1] = (k == 0) ? ity(6'h08, 1, 2, 16'h4) :
                (k == 1) ? ity(OP_RI, 1, 0, 16'h2) : rty(1, 2, 3, 6'h21);
      imem[2] = ity(OP_SW, 0, 3, 16'h120);
      run(20 * DIV);
      chk("R9 illegal pc held", obs_pc, 32'd4);
      chk("R9 illegal flags", {30'd0, halted, illegal}, 32'h3);
      chk("R9 no store after illegal", dmem[8], 32'h1234);
    end

    for (int it = 0; it < 40; it++) begin
      logic [31:0] x, y;
      x = $urandom; y = $urandom;
      case (it)
        0: begin x = 32'h0;         y = 32'h0; end
        1: begin x = 32'h8000_0000; y = 32'h1; end
        2: begin x = 32'h7FFF_FFFF; y = 32'hFFFF_FFFF; end
        3: begin x = 32'hFFFF_FFFF; y = 32'hFFFF_FFFF; end
        default: ;
      endcase
      clear_mem();
      dmem[0] = x; dmem[1] = y; dmem[10] = 32'h1;
      imem[0] = ity(OP_LW, 0, 1, 16'h100);
      imem[1] = ity(OP_LW, 0, 2, 16'h104);
      imem[2] = rty(1, 2, 3, F_NOR);
      imem[3] = rty(1, 2, 4, F_SUBU);
      imem[4] = ity(OP_SW, 0, 3, 16'h120);
      imem[5] = ity(OP_SW, 0, 4, 16'h124);
      imem[6] = ity(OP_RI, 1, 1, 16'h1);
      imem[7] = ity(OP_SW, 0, 0, 16'h128);
      run(20 * DIV);
      chk("R3 random nor", dmem[8], e_nor(x, y));
      chk("R4 random subu", dmem[9], e_sub(x, y));
      chk("R6 random bgez", dmem[10], x[31] ? 32'h0 : 32'h1);
      chk("R8 break halts", {30'd0, halted, illegal}, 32'h2);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule